// File: doc/BRIEF.md
# Bit-level I2C serial EEPROM responder

This block models a small serial EEPROM of 128 or 256 bytes at the level of single bus samples. A host register writes the clock line and the data line. The block takes one sample of both lines on every system clock. From the change between two samples it finds START and STOP conditions and rising and falling clock edges. It counts clock pulses with one tick counter across the whole transfer. The count covers the control byte, its acknowledge, the word address, the address acknowledge and the data bytes that follow.

The memory contents are a fixed preset that is present from reset. The control byte is shifted in most significant bit first. Its last bit picks read (1) or write (0). The word address byte follows, also MSB first. At the last address bit the addressed byte is fetched. In read mode the block drives that byte onto its data output MSB first, one bit for each clock pulse. After the host's acknowledge pulse it moves on to the next address. The host reads the data output back through its register. A data change that lands on a rising clock sample is a protocol violation. It sets a sticky error flag, and the next START clears that flag.

Top module: `seeprom_slave`

## Requirements
- R1: After a synchronous reset, `sda_o` is 1 (released) and `err_o` is 0.
- R2: Until a START is seen, and again after a STOP, clock pulses, data changes and skewed edges have no effect. `sda_o` stays 1 and `err_o` stays unchanged.
- R3: A START is a sample pair where SCL is 1 in both samples and SDA goes from 1 to 0. It opens a transfer, zeroes the pulse count and clears `err_o`. This holds even in the middle of a transfer (repeated START).
- R4: A STOP is a sample pair where SCL is 1 in both samples and SDA goes from 0 to 1. It zeroes the pulse count, sets `sda_o` to 1 in the next cycle and returns the block to idle.
- R5: A bit is taken on a rising SCL sample (0 then 1), and only when SDA holds the same value in both samples. The first eight bits form the control byte, MSB first. Bit 0 of the control byte selects read (1) or write (0).
- R6: On the SCL falling sample after the 8th pulse, `sda_o` goes to 0 and stays 0 through the 9th pulse (the acknowledge). It is released on the falling sample after that pulse. The same happens for pulse 18, after the address byte.
- R7: Pulses 10 to 17 shift in the word address, MSB first. On pulse 17 the byte at address mod DEPTH is fetched.
- R8: In read mode, from the falling sample after pulse 18, `sda_o` carries the fetched byte MSB first. Each falling sample moves to the next bit.
- R9: In write mode, `sda_o` stays 1 from the release after the address acknowledge until the transfer ends.
- R10: In read mode, after the 8 data bits `sda_o` is 1 for the host's acknowledge pulse. That pulse advances the address by one, wrapping at 255 to 0, and the next byte is then served.
- R11: Within a transfer, a rising SCL sample on which SDA also changes sets `err_o`. That pulse is not counted. `err_o` stays 1 until the next START.
- R12: The preset holds bytes 0 to 3 as 0x80, 0x08, 0x04, 0x0D and all other bytes as 0. With DEPTH=128, addresses 128 to 255 alias onto 0 to 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one line sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Clock line value written by the host |
| sda_i | input | 1 | Data line value written by the host |
| sda_o | output | 1 | Data line value driven by the responder (1 = released) |
| err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Each result is due in the clock cycle after the sample that causes it. The edge or condition is decoded from the held previous sample and the new input, and it updates a register at that same edge. So `sda_o` and `err_o` reflect a sample one cycle after it is applied. The bench changes the line inputs only at falling clock edges. After each sample it waits for the next rising edge plus a small delay before it reads any output. Acknowledge bits, data bits and the error flag are all checked at exactly that point. A second instance with 128 bytes shares the line inputs, which exposes the address aliasing.

// File: rtl/seeprom_pkg.sv
// Shared constants, event type and preset contents for the serial EEPROM
// responder. Assumes 8-bit bytes and a pulse count that fits in 5 bits.
package seeprom_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TICK_W = 5;

    // Pulse-count landmarks; the sequence depends on these values.
    localparam logic [TICK_W-1:0] TK_CMD_ACK   = 5'd8;   // count after 8 control bits
    localparam logic [TICK_W-1:0] TK_ADDR_LAST = 5'd16;  // count before last address bit
    localparam logic [TICK_W-1:0] TK_ADDR_ACK  = 5'd17;  // count after last address bit
    localparam logic [TICK_W-1:0] TK_DATA      = 5'd18;  // data phase (saturates here)

    // Decoded line activity for one sample.
    typedef struct packed {
        logic rise;     // SCL 0 -> 1
        logic fall;     // SCL 1 -> 0
        logic start;    // SDA 1 -> 0 with SCL high in both samples
        logic stop;     // SDA 0 -> 1 with SCL high in both samples
        logic skew;     // SCL rising while SDA also changed
        logic bit_val;  // current SDA sample
    } line_evt_t;

    // Preset content of one memory location.
    function automatic logic [BYTE_W-1:0] preset_byte(input int unsigned idx);
        case (idx)
            0:       preset_byte = 8'h80;
            1:       preset_byte = 8'h08;
            2:       preset_byte = 8'h04;
            3:       preset_byte = 8'h0D;
            default: preset_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/seeprom_line_mon.sv
// Line monitor: holds the previous SCL/SDA sample and decodes edges and
// bus conditions against the current one. Assumes the host changes the
// line inputs at most once per system clock.
module seeprom_line_mon
    import seeprom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);

    logic scl_q;
    logic sda_q;

    // Keep the previous sample; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode activity from old and new samples.
    always_comb begin
        evt.rise    = !scl_q && scl_i;
        evt.fall    = scl_q && !scl_i;
        evt.start   = scl_q && scl_i && sda_q && !sda_i;
        evt.stop    = scl_q && scl_i && !sda_q && sda_i;
        evt.skew    = !scl_q && scl_i && (sda_q != sda_i);
        evt.bit_val = sda_i;
    end

endmodule

// File: rtl/seeprom_rom.sv
// Preset memory: DEPTH bytes built from the package preset function,
// read combinationally. Assumes DEPTH is 128 or 256.
module seeprom_rom
    import seeprom_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0]     addr,
    output logic [BYTE_W-1:0] data
);

    logic [BYTE_W-1:0] table_q [DEPTH];

    // One constant entry per location.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = preset_byte(i);
    end

    // Asynchronous read port.
    assign data = table_q[addr];

endmodule

// File: rtl/seeprom_seq.sv
// Transfer sequencer: one pulse counter across control, acknowledge,
// address and data phases; drives the responder's data line on SCL
// falling samples. Assumes decoded events from seeprom_line_mon.
module seeprom_seq
    import seeprom_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_evt_t         evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              sda_o,
    output logic              err_o
);

    logic              busy;
    logic [TICK_W-1:0] tick;
    logic              rw;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        pos;
    logic              sda_drv;
    logic              err;
    logic [BYTE_W-1:0] addr_shift;
    logic [BYTE_W-1:0] next_addr;

    // Address with the current bit appended, and the lookup address.
    always_comb begin
        addr_shift = {addr[BYTE_W-2:0], evt.bit_val};
        next_addr  = (tick == TK_ADDR_LAST) ? addr_shift : addr + 8'd1;
    end
    assign rd_addr = next_addr[AW-1:0];

    // Bus conditions, pulse counting, shifting and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tick    <= '0;
            rw      <= 1'b0;
            addr    <= '0;
            shreg   <= '0;
            pos     <= '0;
            sda_drv <= 1'b1;
            err     <= 1'b0;
        end else if (evt.start) begin
            busy    <= 1'b1;
            tick    <= '0;
            pos     <= '0;
            err     <= 1'b0;
            sda_drv <= 1'b1;
        end else if (evt.stop) begin
            busy    <= 1'b0;
            tick    <= '0;
            pos     <= '0;
            sda_drv <= 1'b1;
        end else if (busy) begin
            if (evt.skew) begin
                err <= 1'b1;
            end else if (evt.rise) begin
                if (tick < TK_CMD_ACK) begin
                    if (tick == TK_CMD_ACK - 5'd1) rw <= evt.bit_val;
                    tick <= tick + 5'd1;
                end else if (tick == TK_CMD_ACK) begin
                    tick <= tick + 5'd1;
                end else if (tick <= TK_ADDR_LAST) begin
                    addr <= addr_shift;
                    tick <= tick + 5'd1;
                    if (tick == TK_ADDR_LAST) shreg <= rd_data;
                end else if (tick == TK_ADDR_ACK) begin
                    tick <= TK_DATA;
                    pos  <= '0;
                end else if (pos == 4'd8) begin
                    pos   <= '0;
                    addr  <= addr + 8'd1;
                    shreg <= rd_data;
                end else begin
                    pos   <= pos + 4'd1;
                    shreg <= {shreg[BYTE_W-2:0], 1'b0};
                end
            end
            if (evt.fall) begin
                if (tick == TK_CMD_ACK || tick == TK_ADDR_ACK)
                    sda_drv <= 1'b0;
                else if (tick == TK_DATA && rw && pos != 4'd8)
                    sda_drv <= shreg[BYTE_W-1];
                else
                    sda_drv <= 1'b1;
            end
        end
    end

    assign sda_o = sda_drv;
    assign err_o = err;

    a_r4_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!busy && tick == '0 && sda_o));

    a_r3_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (busy && tick == '0 && !err_o));

    a_r11_skew_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt.skew && !evt.start && !evt.stop) |=> err_o);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !evt.start) |=> err_o);

    a_r8_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_o) |-> $past(evt.fall || evt.start || evt.stop));

    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sda_o && tick == '0));

    a_r6_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= TK_DATA);

endmodule

// File: rtl/seeprom_slave.sv
// Top level of the serial EEPROM responder: line monitor, sequencer and
// preset memory. Assumes one host-written SCL/SDA sample per clock.
module seeprom_slave
    import seeprom_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic err_o
);

    localparam int unsigned AW = $clog2(DEPTH);

    line_evt_t         evt;
    logic [AW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_data;

    seeprom_line_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    seeprom_seq #(.DEPTH(DEPTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .sda_o   (sda_o),
        .err_o   (err_o)
    );

    seeprom_rom #(.DEPTH(DEPTH)) u_rom (
        .addr (rd_addr),
        .data (rd_data)
    );

endmodule

// File: tb/seeprom_slave_tb.sv
module seeprom_slave_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_big, err_big, sda_small, err_small;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seeprom_slave #(.DEPTH(256)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_o(sda_big), .err_o(err_big));

    seeprom_slave #(.DEPTH(128)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_o(sda_small), .err_o(err_small));

    function automatic logic [7:0] exp_byte(input int idx);
        case (idx)
            0: return 8'h80;
            1: return 8'h08;
            2: return 8'h04;
            3: return 8'h0D;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One line sample; outputs are valid when this returns.
    task automatic put(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        put(0, 1); put(1, 1); put(1, 0); put(0, 0);
    endtask

    task automatic do_stop();
        put(0, 0); put(1, 0); put(1, 1);
    endtask

    task automatic send_bit(input logic b);
        put(0, b); put(1, b); put(0, b);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // Acknowledge pulse with the responder expected to hold SDA low.
    task automatic ack_pulse(input string tag);
        chk({tag, " ack before pulse"}, {7'd0, sda_big}, 8'h00);
        put(0, 1);
        put(1, 1);
        chk({tag, " ack during pulse"}, {7'd0, sda_big}, 8'h00);
        put(0, 1);
    endtask

    // Read one byte from both instances; host then acks (or not).
    task automatic read_byte(input string tag, input logic [7:0] eb, input logic [7:0] es,
                             input logic host_ack);
        logic [7:0] gb, gs;
        put(0, 1);
        for (int i = 7; i >= 0; i--) begin
            put(1, 1);
            gb[i] = sda_big;
            gs[i] = sda_small;
            put(0, 1);
        end
        chk({tag, " 256-byte data"}, gb, eb);
        chk({tag, " 128-byte data"}, gs, es);
        chk("R10 released for host ack", {7'd0, sda_big}, 8'h01);
        put(0, host_ack ? 1'b0 : 1'b1);
        put(1, host_ack ? 1'b0 : 1'b1);
        put(0, host_ack ? 1'b0 : 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 sda released", {7'd0, sda_big}, 8'h01);
        chk("R1 error clear", {7'd0, err_big}, 8'h00);
    endtask

    task automatic t_idle();
        send_byte(8'hA1);
        chk("R2 no ack when idle", {7'd0, sda_big}, 8'h01);
        put(0, 0); put(1, 1); put(0, 1);
        chk("R2 skew ignored when idle", {7'd0, err_big}, 8'h00);
        chk("R2 sda still released", {7'd0, sda_big}, 8'h01);
    endtask

    task automatic t_read_seq();
        do_start();
        send_byte(8'hA1);
        ack_pulse("R6 R5 control");
        chk("R6 released after ack", {7'd0, sda_big}, 8'h01);
        send_byte(8'h00);
        ack_pulse("R6 R7 address");
        read_byte("R8 R12 addr0", exp_byte(0), exp_byte(0), 1'b1);
        read_byte("R10 addr1", exp_byte(1), exp_byte(1), 1'b1);
        read_byte("R10 addr2", exp_byte(2), exp_byte(2), 1'b1);
        read_byte("R10 addr3", exp_byte(3), exp_byte(3), 1'b0);
        do_stop();
        chk("R4 released after stop", {7'd0, sda_big}, 8'h01);
    endtask

    task automatic t_alias();
        do_start();
        send_byte(8'hA1);
        ack_pulse("R5 control");
        send_byte(8'h81);
        ack_pulse("R7 address 0x81");
        read_byte("R12 alias 0x81", exp_byte(8'h81), exp_byte(8'h01), 1'b1);
        read_byte("R12 alias 0x82", exp_byte(8'h82), exp_byte(8'h02), 1'b0);
        do_stop();
    endtask

    task automatic t_wrap();
        do_start();
        send_byte(8'hA1);
        ack_pulse("R5 control");
        send_byte(8'hFF);
        ack_pulse("R7 address 0xFF");
        read_byte("R10 last byte", exp_byte(8'hFF), exp_byte(8'h7F), 1'b1);
        read_byte("R10 wrap to 0", exp_byte(0), exp_byte(0), 1'b0);
        do_stop();
    endtask

    task automatic t_write();
        logic seen_low;
        do_start();
        send_byte(8'hA0);
        ack_pulse("R5 write control");
        send_byte(8'h02);
        ack_pulse("R7 write address");
        seen_low = 1'b0;
        for (int i = 0; i < 9; i++) begin
            put(0, 0); if (!sda_big) seen_low = 1'b1;
            put(1, 0); if (!sda_big) seen_low = 1'b1;
            put(0, 0); if (!sda_big) seen_low = 1'b1;
        end
        chk("R9 write mode keeps sda released", {7'd0, seen_low}, 8'h00);
        do_stop();
    endtask

    task automatic t_stop_mid();
        do_start();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        do_stop();
        chk("R4 released at stop", {7'd0, sda_big}, 8'h01);
        send_byte(8'hA1);
        chk("R4 R2 no ack after stop", {7'd0, sda_big}, 8'h01);
    endtask

    task automatic t_restart();
        do_start();
        send_bit(1); send_bit(0); send_bit(1);
        do_start();
        send_byte(8'hA1);
        ack_pulse("R3 repeated start count");
        do_stop();
    endtask

    task automatic t_error();
        do_start();
        put(0, 0); put(1, 1);
        chk("R11 skew sets error", {7'd0, err_big}, 8'h01);
        put(0, 1);
        send_byte(8'hA1);
        chk("R11 error sticky", {7'd0, err_big}, 8'h01);
        ack_pulse("R11 skewed pulse not counted");
        do_start();
        chk("R3 start clears error", {7'd0, err_big}, 8'h00);
        do_stop();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_idle();
        t_read_seq();
        t_alias();
        t_wrap();
        t_write();
        t_stop_mid();
        t_restart();
        t_error();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule